// File: doc/BRIEF.md
# Virtual Interrupt CPU Interface

This block presents a guest operating system with its own interrupt interface, separate from the physical one. The hypervisor fills a small bank of list registers through a write port. Each list register holds one virtual interrupt: its ID, a priority, a group bit and a lifecycle state. The hypervisor can read back the state of any entry through a read port. The guest then runs its interrupt flow directly against the block, with no hypervisor involvement. It acknowledges the most urgent pending entry, services it, and writes the same ID back to retire it.

The group bit of an entry sets how it is signalled. Group 0 entries drive the virtual FIQ line and group 1 entries drive the virtual IRQ line. The hypervisor may therefore present an interrupt that arrived as physical group 1 under either virtual group. Each virtual line has its own guest-side enable, independent of any physical interrupt masking. When no entry is left pending, a maintenance line tells the hypervisor that the list needs refilling.

Top module: `vci_cpu_if`

## Requirements
- R1: While reset is asserted and after it, every list register is invalid, `virq`, `vfiq` and `gst_ack_valid` are low and `maint_irq` is high.
- R2: A hypervisor write (`hv_wr_en`) loads ID, priority, group and state into entry `hv_wr_idx` at the next clock edge. This write takes precedence over any guest acknowledge or end of interrupt that touches the same entry in that cycle. The state codes are 0 invalid, 1 pending and 2 active, and code 3 is stored as invalid.
- R3: One cycle after `gst_ack_req`, `gst_ack_valid` is high for one cycle and `gst_ack_id` holds the ID of the pending entry with the numerically lowest priority value. On equal priority the lowest entry index wins.
- R4: The entry chosen by an acknowledge becomes active at the same clock edge.
- R5: An acknowledge with no pending entry returns ID 1023 and changes no entry.
- R6: An end of interrupt (`gst_eoi`) sets to invalid every entry that is active and holds ID `gst_eoi_id`. It looks only at entries that are active before the edge, so a pending entry acknowledged in the same cycle is unaffected.
- R7: An end of interrupt whose ID matches no active entry changes no entry.
- R8: `vfiq` is high when `gst_fiq_en` is high and some pending entry has group bit 0. `virq` is high when `gst_irq_en` is high and some pending entry has group bit 1. Active entries signal nothing.
- R9: `maint_irq` is high exactly when no entry is pending, whatever the enables.
- R10: `hv_rd_state` shows the current state code of entry `hv_rd_idx`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hv_wr_en | input | 1 | Hypervisor list register write strobe |
| hv_wr_idx | input | 2 | Entry to write |
| hv_wr_id | input | 10 | Interrupt ID to load |
| hv_wr_prio | input | 5 | Priority to load (lower value is more urgent) |
| hv_wr_grp | input | 1 | Group: 0 signals FIQ, 1 signals IRQ |
| hv_wr_state | input | 2 | State code to load |
| hv_rd_idx | input | 2 | Entry to read back |
| hv_rd_state | output | 2 | State code of the entry being read |
| gst_ack_req | input | 1 | Guest acknowledge strobe |
| gst_ack_valid | output | 1 | Acknowledge result valid |
| gst_ack_id | output | 10 | Acknowledged ID, or 1023 if spurious |
| gst_eoi | input | 1 | Guest end-of-interrupt strobe |
| gst_eoi_id | input | 10 | ID being retired |
| gst_irq_en | input | 1 | Guest enable for the virtual IRQ line |
| gst_fiq_en | input | 1 | Guest enable for the virtual FIQ line |
| virq | output | 1 | Virtual IRQ to the guest |
| vfiq | output | 1 | Virtual FIQ to the guest |
| maint_irq | output | 1 | Maintenance interrupt to the hypervisor |

## Verification
The assertions assume that the hypervisor never loads ID 1023 into a list register, so a returned 1023 always means spurious. They also assume that the acknowledge strobe is low during reset and the cycles of reset release. The stimulus uses only IDs below 1023 and keeps every strobe idle until several cycles after reset is released. The collision cases, a write racing an acknowledge and an end of interrupt racing an acknowledge, are driven on purpose. The hypervisor never writes invalid-to-active under a pending acknowledge in a way that would need an ordering not stated in R2 and R6.

// File: rtl/vci_pkg.sv
package vci_pkg;
  typedef enum logic [1:0] {
    LR_INVALID = 2'd0,
    LR_PENDING = 2'd1,
    LR_ACTIVE  = 2'd2,
    LR_RSVD    = 2'd3
  } lr_state_e;
endpackage

// File: rtl/vci_lr_bank.sv
module vci_lr_bank
  import vci_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 5,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic              wr_grp,
  input  logic [1:0]        wr_state,
  input  logic [NUM_LR-1:0] take,
  input  logic              eoi_en,
  input  logic [ID_W-1:0]   eoi_id,
  output logic [ID_W-1:0]   lr_id   [NUM_LR],
  output logic [PRIO_W-1:0] lr_prio [NUM_LR],
  output logic [NUM_LR-1:0] lr_grp,
  output lr_state_e         lr_st   [NUM_LR]
);

  for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
    lr_state_e         st_q, st_d;
    logic [ID_W-1:0]   id_q;
    logic [PRIO_W-1:0] prio_q;
    logic              grp_q;
    logic              hit_wr, hit_eoi;

    // Next-state: hypervisor write wins, then acknowledge, then retire.
    always_comb begin
      hit_wr  = wr_en && (wr_idx == IDX_W'(g));
      hit_eoi = eoi_en && (st_q == LR_ACTIVE) && (id_q == eoi_id);
      st_d    = st_q;
      if (hit_wr) begin
        st_d = (wr_state == 2'd3) ? LR_INVALID : lr_state_e'(wr_state);
      end else if (take[g]) begin
        st_d = LR_ACTIVE;
      end else if (hit_eoi) begin
        st_d = LR_INVALID;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= LR_INVALID;
      end else begin
        st_q <= st_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q   <= '0;
        prio_q <= '0;
        grp_q  <= 1'b0;
      end else if (hit_wr) begin
        id_q   <= wr_id;
        prio_q <= wr_prio;
        grp_q  <= wr_grp;
      end
    end

    assign lr_st[g]   = st_q;
    assign lr_id[g]   = id_q;
    assign lr_prio[g] = prio_q;
    assign lr_grp[g]  = grp_q;
  end

endmodule

// File: rtl/vci_prio_sel.sv
module vci_prio_sel #(
  parameter int NUM_LR = 4,
  parameter int PRIO_W = 5,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic [NUM_LR-1:0] cand,
  input  logic [PRIO_W-1:0] prio [NUM_LR],
  output logic              found,
  output logic [IDX_W-1:0]  win_idx,
  output logic [NUM_LR-1:0] win_oh
);

  logic [PRIO_W-1:0] best;

  // Ascending scan, replace only on strictly better: lowest index wins ties.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '1;
    for (int i = 0; i < NUM_LR; i++) begin
      if (cand[i] && (!found || (prio[i] < best))) begin
        found   = 1'b1;
        best    = prio[i];
        win_idx = IDX_W'(i);
      end
    end
    win_oh = '0;
    if (found) win_oh[win_idx] = 1'b1;
  end

endmodule

// File: rtl/vci_sig_out.sv
module vci_sig_out #(
  parameter int NUM_LR = 4
) (
  input  logic [NUM_LR-1:0] pend,
  input  logic [NUM_LR-1:0] grp,
  input  logic              irq_en,
  input  logic              fiq_en,
  output logic              virq,
  output logic              vfiq,
  output logic              maint
);

  always_comb begin
    virq  = irq_en && (|(pend & grp));
    vfiq  = fiq_en && (|(pend & ~grp));
    maint = ~(|pend);
  end

endmodule

// File: rtl/vci_cpu_if.sv
module vci_cpu_if
  import vci_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 5,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_wr_en,
  input  logic [IDX_W-1:0]  hv_wr_idx,
  input  logic [ID_W-1:0]   hv_wr_id,
  input  logic [PRIO_W-1:0] hv_wr_prio,
  input  logic              hv_wr_grp,
  input  logic [1:0]        hv_wr_state,
  input  logic [IDX_W-1:0]  hv_rd_idx,
  output logic [1:0]        hv_rd_state,
  input  logic              gst_ack_req,
  output logic              gst_ack_valid,
  output logic [ID_W-1:0]   gst_ack_id,
  input  logic              gst_eoi,
  input  logic [ID_W-1:0]   gst_eoi_id,
  input  logic              gst_irq_en,
  input  logic              gst_fiq_en,
  output logic              virq,
  output logic              vfiq,
  output logic              maint_irq
);

  localparam logic [ID_W-1:0] SPUR_ID = '1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [ID_W-1:0]   lr_id   [NUM_LR];
  logic [PRIO_W-1:0] lr_prio [NUM_LR];
  logic [NUM_LR-1:0] lr_grp;
  lr_state_e         lr_st   [NUM_LR];
  logic [NUM_LR-1:0] pend;
  logic [NUM_LR-1:0] win_oh;
  logic [NUM_LR-1:0] take;
  logic [IDX_W-1:0]  win_idx;
  logic              found;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_pend
    assign pend[g] = (lr_st[g] == LR_PENDING);
  end

  assign take = gst_ack_req ? win_oh : '0;

  vci_lr_bank #(.NUM_LR(NUM_LR), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (hv_wr_en),
    .wr_idx   (hv_wr_idx),
    .wr_id    (hv_wr_id),
    .wr_prio  (hv_wr_prio),
    .wr_grp   (hv_wr_grp),
    .wr_state (hv_wr_state),
    .take     (take),
    .eoi_en   (gst_eoi),
    .eoi_id   (gst_eoi_id),
    .lr_id    (lr_id),
    .lr_prio  (lr_prio),
    .lr_grp   (lr_grp),
    .lr_st    (lr_st)
  );

  vci_prio_sel #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_sel (
    .cand    (pend),
    .prio    (lr_prio),
    .found   (found),
    .win_idx (win_idx),
    .win_oh  (win_oh)
  );

  vci_sig_out #(.NUM_LR(NUM_LR)) u_sig (
    .pend   (pend),
    .grp    (lr_grp),
    .irq_en (gst_irq_en),
    .fiq_en (gst_fiq_en),
    .virq   (virq),
    .vfiq   (vfiq),
    .maint  (maint_irq)
  );

  // Acknowledge response register with written-out enable.
  logic [ID_W-1:0] ack_id_d;
  assign ack_id_d = found ? lr_id[win_idx] : SPUR_ID;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gst_ack_valid <= 1'b0;
    end else begin
      gst_ack_valid <= gst_ack_req;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gst_ack_id <= '0;
    end else if (gst_ack_req) begin
      gst_ack_id <= ack_id_d;
    end
  end

  assign hv_rd_state = lr_st[hv_rd_idx];

endmodule

// File: rtl/vci_cpu_if_chk.sv
module vci_cpu_if_chk #(
  parameter int ID_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gst_ack_req,
  input logic            gst_ack_valid,
  input logic [ID_W-1:0] gst_ack_id,
  input logic            gst_irq_en,
  input logic            gst_fiq_en,
  input logic            virq,
  input logic            vfiq,
  input logic            maint_irq,
  input logic [1:0]      hv_rd_state
);

  localparam logic [ID_W-1:0] SPUR_ID = '1;

  // R3
  ack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gst_ack_req |=> gst_ack_valid);

  // R3
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gst_ack_req |=> !gst_ack_valid);

  // R5
  spur_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gst_ack_valid && gst_ack_id == SPUR_ID) |-> $past(maint_irq));

  // R5
  real_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gst_ack_req) && !$past(maint_irq)) |-> (gst_ack_id != SPUR_ID));

  // R8
  virq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    virq |-> gst_irq_en);

  // R8
  vfiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfiq |-> gst_fiq_en);

  // R9
  maint_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_irq |-> (!virq && !vfiq));

  // R2
  no_rsvd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_rd_state != 2'b11);

endmodule

bind vci_cpu_if vci_cpu_if_chk #(.ID_W(ID_W)) u_vci_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .gst_ack_req   (gst_ack_req),
  .gst_ack_valid (gst_ack_valid),
  .gst_ack_id    (gst_ack_id),
  .gst_irq_en    (gst_irq_en),
  .gst_fiq_en    (gst_fiq_en),
  .virq          (virq),
  .vfiq          (vfiq),
  .maint_irq     (maint_irq),
  .hv_rd_state   (hv_rd_state)
);

// File: tb/vci_cpu_if_bench.sv
`timescale 1ns/1ps
module vci_cpu_if_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hv_wr_en;
  logic [1:0] hv_wr_idx;
  logic [9:0] hv_wr_id;
  logic [4:0] hv_wr_prio;
  logic       hv_wr_grp;
  logic [1:0] hv_wr_state;
  logic [1:0] hv_rd_idx;
  logic [1:0] hv_rd_state;
  logic       gst_ack_req;
  logic       gst_ack_valid;
  logic [9:0] gst_ack_id;
  logic       gst_eoi;
  logic [9:0] gst_eoi_id;
  logic       gst_irq_en;
  logic       gst_fiq_en;
  logic       virq;
  logic       vfiq;
  logic       maint_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vci_cpu_if u_vci_cpu_if (
    .clk(clk), .rst_n(rst_n),
    .hv_wr_en(hv_wr_en), .hv_wr_idx(hv_wr_idx), .hv_wr_id(hv_wr_id),
    .hv_wr_prio(hv_wr_prio), .hv_wr_grp(hv_wr_grp), .hv_wr_state(hv_wr_state),
    .hv_rd_idx(hv_rd_idx), .hv_rd_state(hv_rd_state),
    .gst_ack_req(gst_ack_req), .gst_ack_valid(gst_ack_valid), .gst_ack_id(gst_ack_id),
    .gst_eoi(gst_eoi), .gst_eoi_id(gst_eoi_id),
    .gst_irq_en(gst_irq_en), .gst_fiq_en(gst_fiq_en),
    .virq(virq), .vfiq(vfiq), .maint_irq(maint_irq)
  );

  // op: 0 idle, 1 hypervisor write, 2 acknowledge, 3 end of interrupt
  typedef struct packed {
    logic [1:0] op;
    logic [1:0] idx;
    logic [9:0] id;
    logic [4:0] prio;
    logic       grp;
    logic [1:0] st;
    logic       ien;
    logic       fen;
    logic [1:0] rd;
    logic       ack;
    logic [9:0] xid;
    logic       xvirq;
    logic       xvfiq;
    logic       xmaint;
    logic [1:0] xrd;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{0,0,0,0,0,0,1,1,0,0,0,0,0,1,0},
    '{1,0,40,8,1,1,1,1,0,0,0,1,0,0,1},
    '{1,1,41,3,0,1,1,1,1,0,0,1,1,0,1},
    '{1,2,42,3,1,1,1,1,2,0,0,1,1,0,1},
    '{2,0,0,0,0,0,1,1,1,1,41,1,0,0,2},
    '{2,0,0,0,0,0,1,1,2,1,42,1,0,0,2},
    '{3,0,99,0,0,0,1,1,1,0,0,1,0,0,2},
    '{2,0,0,0,0,0,1,1,0,1,40,0,0,1,2},
    '{2,0,0,0,0,0,1,1,0,1,1023,0,0,1,2},
    '{3,0,41,0,0,0,1,1,1,0,0,0,0,1,0},
    '{3,0,42,0,0,0,1,1,2,0,0,0,0,1,0},
    '{1,3,7,0,0,1,1,0,3,0,0,0,0,0,1},
    '{0,0,0,0,0,0,1,1,3,0,0,0,1,0,1},
    '{1,0,5,31,1,1,0,1,0,0,0,0,1,0,1},
    '{0,0,0,0,0,0,1,1,0,0,0,1,1,0,1},
    '{1,2,9,2,1,3,1,1,2,0,0,1,1,0,0},
    '{2,0,0,0,0,0,1,1,3,1,7,1,0,0,2},
    '{3,0,7,0,0,0,1,1,3,0,0,1,0,0,0},
    '{2,0,0,0,0,0,1,1,0,1,5,0,0,1,2},
    '{3,0,5,0,0,0,1,1,0,0,0,0,0,1,0},
    '{1,1,77,1,0,2,1,1,1,0,0,0,0,1,2},
    '{3,0,77,0,0,0,1,1,1,0,0,0,0,1,0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    hv_wr_en    = 1'b0;
    hv_wr_idx   = '0;
    hv_wr_id    = '0;
    hv_wr_prio  = '0;
    hv_wr_grp   = 1'b0;
    hv_wr_state = '0;
    gst_ack_req = 1'b0;
    gst_eoi     = 1'b0;
    gst_eoi_id  = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n      = 1'b0;
    hv_rd_idx  = '0;
    gst_irq_en = 1'b1;
    gst_fiq_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "maint in reset", maint_irq, 1);
    check("R1", "virq in reset", virq, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      hv_rd_idx = 2'(i);
      #0.1;
      check("R1", "entry state after reset", hv_rd_state, 0);
    end
    check("R1", "ack_valid after reset", gst_ack_valid, 0);
    check("R1", "vfiq after reset", vfiq, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      vec_t  t;
      string rq;
      t = VECS[v];
      idle();
      case (t.op)
        2'd1: begin
          hv_wr_en = 1'b1; hv_wr_idx = t.idx; hv_wr_id = t.id;
          hv_wr_prio = t.prio; hv_wr_grp = t.grp; hv_wr_state = t.st;
        end
        2'd2: gst_ack_req = 1'b1;
        2'd3: begin gst_eoi = 1'b1; gst_eoi_id = t.id; end
        default: ;
      endcase
      gst_irq_en = t.ien;
      gst_fiq_en = t.fen;
      hv_rd_idx  = t.rd;
      @(posedge clk);
      @(negedge clk);
      case (t.op)
        2'd1:    rq = "R2";
        2'd2:    rq = "R4";
        2'd3:    rq = (t.id == 10'd99) ? "R7" : "R6";
        default: rq = "R10";
      endcase
      check(rq, "entry state", hv_rd_state, t.xrd);
      check("R3", "ack_valid", gst_ack_valid, t.ack);
      if (t.ack) check((t.xid == 10'd1023) ? "R5" : "R3", "ack id", gst_ack_id, t.xid);
      check("R8", "virq", virq, t.xvirq);
      check("R8", "vfiq", vfiq, t.xvfiq);
      check("R9", "maint", maint_irq, t.xmaint);
    end

    // R2: write and acknowledge of the same entry in one cycle
    idle();
    gst_irq_en = 1'b1; gst_fiq_en = 1'b1;
    hv_wr_en = 1'b1; hv_wr_idx = 2'd3; hv_wr_id = 10'd7; hv_wr_prio = 5'd0;
    hv_wr_grp = 1'b0; hv_wr_state = 2'd1;
    @(posedge clk); @(negedge clk);
    hv_wr_id = 10'd8; hv_wr_prio = 5'd1; hv_wr_grp = 1'b1;
    gst_ack_req = 1'b1; hv_rd_idx = 2'd3;
    @(posedge clk); @(negedge clk);
    check("R3", "ack id under write race", gst_ack_id, 7);
    check("R2", "write wins over ack", hv_rd_state, 1);
    check("R8", "virq from rewritten entry", virq, 1);
    check("R8", "vfiq cleared", vfiq, 0);
    idle();
    gst_ack_req = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2", "rewritten id acknowledged", gst_ack_id, 8);
    check("R4", "entry active", hv_rd_state, 2);

    // R6: end of interrupt and acknowledge in the same cycle
    idle();
    hv_wr_en = 1'b1; hv_wr_idx = 2'd1; hv_wr_id = 10'd50; hv_wr_prio = 5'd2;
    hv_wr_grp = 1'b0; hv_wr_state = 2'd1;
    @(posedge clk); @(negedge clk);
    idle();
    gst_ack_req = 1'b1; gst_eoi = 1'b1; gst_eoi_id = 10'd8; hv_rd_idx = 2'd3;
    @(posedge clk); @(negedge clk);
    check("R6", "retired entry", hv_rd_state, 0);
    check("R3", "ack id during eoi", gst_ack_id, 50);
    hv_rd_idx = 2'd1;
    #0.1;
    check("R6", "acked entry untouched by eoi", hv_rd_state, 2);

    // R1: reset in mid-run with a pending entry
    idle();
    hv_wr_en = 1'b1; hv_wr_idx = 2'd0; hv_wr_id = 10'd3; hv_wr_prio = 5'd4;
    hv_wr_grp = 1'b1; hv_wr_state = 2'd1;
    @(posedge clk); @(negedge clk);
    idle();
    check("R8", "virq before reset", virq, 1);
    rst_n = 1'b0;
    #1;
    hv_rd_idx = 2'd0;
    #0.1;
    check("R1", "virq during reset", virq, 0);
    check("R1", "maint during reset", maint_irq, 1);
    check("R1", "entry cleared by reset", hv_rd_state, 0);
    check("R1", "ack_valid during reset", gst_ack_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule